// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory through a single read port. The port holds an address and a request strobe until memory answers with an acknowledge and a 32-bit data word. The walk resolves either a 4 MiB superpage, after one read, or a 4 KiB page reached through a second-level table, after two reads. For user accesses it checks the read, write and execute grants of the final descriptor.

A request carries the virtual address, an access kind, a user flag, the table base and a translation enable. When translation is off, or when a privileged access targets the lower half of the address space, the result comes back without any memory read. Every request ends with a one-cycle completion pulse. The pulse carries the physical address, the granted permissions, the page size and a fault code. A failed translation also raises an instruction or a data trap and updates a sticky fault status and a fault address. Requests are taken only while the walker is idle.

Top module: `ptw_xlate`

## Requirements
- R1: With `xlat_en_i` low, a request completes one cycle after acceptance with `pa_o` equal to the VA, `perm_o` = 3'b111, `big_page_o` = 0, fault code 0, and no memory read.
- R2: With `xlat_en_i` high, a non-user request whose VA bit 31 is 0 completes one cycle after acceptance with `pa_o` = VA with bit 31 set, `perm_o` = 3'b111, fault code 0, and no memory read. All other enabled requests start a walk.
- R3: The first read address is {base[31:12], VA[31:22], 2'b00}. The second read address is {desc[31:12], VA[21:12], 2'b00}.
- R4: In a first-level descriptor, bits [1:0] select the kind: 2'b10 is a superpage and 2'b00 is a table pointer. Any other value ends the walk with fault code 0x1F. Bit 2 is the present bit.
- R5: A present superpage gives `pa_o` = {desc[31:22], VA[21:0]} and `big_page_o` = 1. An absent superpage gives fault code 0x0B.
- R6: An absent table pointer gives code 0x05. An absent second-level entry gives code 0x08. A present one gives `pa_o` = {desc[31:12], VA[11:0]} and `big_page_o` = 0. Any miss or wrong kind reports `pa_o` = 0 and `perm_o` = 0.
- R7: `perm_o` = {desc[8], desc[7], desc[6]}, meaning read, write, execute. The access kind is encoded 00 read, 01 write, 10 execute, 11 read. A user access whose grant is clear gets code 0x11 for a read, 0x12 for a write and 0x13 for an execute. Non-user accesses never get a permission fault.
- R8: When the fault code is nonzero, `fault_status_o` and `fault_addr_o` take the code and the VA, and hold them until the next fault. `itrap_o` pulses with `done_o` for an execute access, and `dtrap_o` pulses for any other access.
- R9: `req_ready_o` is high only while the walker is idle. A request presented while it is busy is ignored. Each accepted request gives exactly one `done_o` pulse. After reset, the walker is idle and the status registers are zero.
- R10: `mem_req_o` stays high with a constant `mem_addr_o` until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, so a request is accepted |
| req_va_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| req_user_i | input | 1 | User-level access |
| xlat_en_i | input | 1 | Translation enable |
| tbl_base_i | input | 32 | First-level table base (bits 31:12 used) |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Descriptor word |
| done_o | output | 1 | Translation finished (one cycle) |
| pa_o | output | 32 | Physical address |
| perm_o | output | 3 | Grants {read, write, execute} |
| big_page_o | output | 1 | 1 = 4 MiB superpage, 0 = 4 KiB page |
| fault_code_o | output | 8 | Fault code, 0 if none |
| itrap_o | output | 1 | Instruction trap pulse |
| dtrap_o | output | 1 | Data trap pulse |
| fault_status_o | output | 8 | Last nonzero fault code |
| fault_addr_o | output | 32 | VA of the last fault |

## Verification
A stuck or wrong walk state shows at the ports within one memory round trip. The number of reads between two completions stops matching the descriptor chain, or an extra or missing `done_o` pulse leaves the expected-result queue out of step. A corrupted captured VA or access kind shows in the same completion, as a wrong physical address, a wrong permission code or the wrong trap line. Sticky status corruption is caught at the next completion, because every result is compared against the last fault expected so far.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int FC_W = 8;
   localparam logic [FC_W-1:0] FC_NONE       = 8'h00;
   localparam logic [FC_W-1:0] FC_TBL_MISS   = 8'h05;
   localparam logic [FC_W-1:0] FC_PAGE_MISS  = 8'h08;
   localparam logic [FC_W-1:0] FC_SUPER_MISS = 8'h0B;
   localparam logic [FC_W-1:0] FC_NO_RD      = 8'h11;
   localparam logic [FC_W-1:0] FC_NO_WR      = 8'h12;
   localparam logic [FC_W-1:0] FC_NO_EX      = 8'h13;
   localparam logic [FC_W-1:0] FC_BAD_KIND   = 8'h1F;

   localparam logic [1:0] KIND_TABLE = 2'b00;
   localparam logic [1:0] KIND_SUPER = 2'b10;

   localparam logic [1:0] ACC_RD = 2'b00;
   localparam logic [1:0] ACC_WR = 2'b01;
   localparam logic [1:0] ACC_EX = 2'b10;

   typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} wstate_e;
endpackage

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec #(
   parameter int DATA_W      = 32,
   parameter int PRESENT_BIT = 2,
   parameter int RD_BIT      = 8,
   parameter int WR_BIT      = 7,
   parameter int EX_BIT      = 6
) (
   input  logic [DATA_W-1:0] desc_i,
   output logic              is_table_o,
   output logic              is_super_o,
   output logic              present_o,
   output logic [2:0]        perm_o
);
   import ptw_pkg::*;

   assign is_table_o = (desc_i[1:0] == KIND_TABLE);
   assign is_super_o = (desc_i[1:0] == KIND_SUPER);
   assign present_o  = desc_i[PRESENT_BIT];
   assign perm_o     = {desc_i[RD_BIT], desc_i[WR_BIT], desc_i[EX_BIT]};

   logic unused_desc;
   assign unused_desc = ^desc_i;
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
   input  logic       user_i,
   input  logic [1:0] acc_i,
   input  logic [2:0] perm_i,
   output logic [7:0] code_o
);
   import ptw_pkg::*;

   logic [2:0] want;
   logic [2:0] viol;

   assign want[2] = (acc_i == ACC_RD) || (acc_i == 2'b11);
   assign want[1] = (acc_i == ACC_WR);
   assign want[0] = (acc_i == ACC_EX);

   for (genvar i = 0; i < 3; i++) begin : g_cls
      assign viol[i] = user_i & want[i] & ~perm_i[i];
   end

   always_comb begin
      if (viol[2])      code_o = FC_NO_RD;
      else if (viol[1]) code_o = FC_NO_WR;
      else if (viol[0]) code_o = FC_NO_EX;
      else              code_o = FC_NONE;
   end
endmodule

// File: rtl/ptw_xlate.sv
module ptw_xlate #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int SUPER_BITS  = 22,
   parameter int PRESENT_BIT = 2,
   parameter int RD_BIT      = 8,
   parameter int WR_BIT      = 7,
   parameter int EX_BIT      = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [31:0]       req_va_i,
   input  logic [1:0]        req_acc_i,
   input  logic              req_user_i,
   input  logic              xlat_en_i,
   input  logic [31:0]       tbl_base_i,
   output logic              mem_req_o,
   output logic [31:0]       mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_data_i,
   output logic              done_o,
   output logic [31:0]       pa_o,
   output logic [2:0]        perm_o,
   output logic              big_page_o,
   output logic [7:0]        fault_code_o,
   output logic              itrap_o,
   output logic              dtrap_o,
   output logic [7:0]        fault_status_o,
   output logic [31:0]       fault_addr_o
);
   import ptw_pkg::*;

   localparam int L1_IDX_W = ADDR_W - SUPER_BITS;
   localparam int L2_IDX_W = SUPER_BITS - PAGE_BITS;
   localparam logic [ADDR_W-1:0] KSEG_SET = {1'b1, {(ADDR_W-1){1'b0}}};

   if (ADDR_W != 32) begin : g_bad_width
      $error("ptw_xlate: ADDR_W must be 32 to match the port widths");
   end
   if (PAGE_BITS != L1_IDX_W + 2 || PAGE_BITS != L2_IDX_W + 2) begin : g_bad_split
      $error("ptw_xlate: each table index plus word offset must fill one page");
   end
   if (RD_BIT >= PAGE_BITS || WR_BIT >= PAGE_BITS || EX_BIT >= PAGE_BITS ||
       PRESENT_BIT >= PAGE_BITS || PRESENT_BIT < 2) begin : g_bad_bits
      $error("ptw_xlate: descriptor flag bits must sit in the page offset above the kind field");
   end

   wstate_e           state_q, nxt_state;
   logic [ADDR_W-1:0] va_q;
   logic [1:0]        acc_q;
   logic              user_q;
   logic [ADDR_W-1:0] addr_q, nxt_addr;

   logic              fin;
   logic [ADDR_W-1:0] fin_pa;
   logic [2:0]        fin_perm;
   logic              fin_big;
   logic [FC_W-1:0]   fin_code;

   logic              d_table, d_super, d_present;
   logic [2:0]        d_perm;
   logic [FC_W-1:0]   p_code;

   ptw_desc_dec #(
      .DATA_W(ADDR_W), .PRESENT_BIT(PRESENT_BIT),
      .RD_BIT(RD_BIT), .WR_BIT(WR_BIT), .EX_BIT(EX_BIT)
   ) u_dec (
      .desc_i(mem_data_i), .is_table_o(d_table), .is_super_o(d_super),
      .present_o(d_present), .perm_o(d_perm)
   );

   ptw_perm_chk u_perm (
      .user_i(user_q), .acc_i(acc_q), .perm_i(d_perm), .code_o(p_code)
   );

   always_comb begin
      nxt_state = state_q;
      nxt_addr  = addr_q;
      fin       = 1'b0;
      fin_pa    = '0;
      fin_perm  = '0;
      fin_big   = 1'b0;
      fin_code  = FC_NONE;
      unique case (state_q)
         ST_IDLE: if (req_valid_i) begin
            if (!xlat_en_i) begin
               fin      = 1'b1;
               fin_pa   = req_va_i;
               fin_perm = '1;
            end else if (!req_user_i && !req_va_i[ADDR_W-1]) begin
               fin      = 1'b1;
               fin_pa   = req_va_i | KSEG_SET;
               fin_perm = '1;
            end else begin
               nxt_state = ST_L1;
               nxt_addr  = {tbl_base_i[ADDR_W-1:PAGE_BITS],
                            req_va_i[ADDR_W-1:SUPER_BITS], 2'b00};
            end
         end
         ST_L1: if (mem_ack_i) begin
            if (d_super) begin
               fin = 1'b1;
               if (d_present) begin
                  fin_pa   = {mem_data_i[ADDR_W-1:SUPER_BITS], va_q[SUPER_BITS-1:0]};
                  fin_perm = d_perm;
                  fin_big  = 1'b1;
                  fin_code = p_code;
               end else begin
                  fin_code = FC_SUPER_MISS;
               end
            end else if (d_table) begin
               if (d_present) begin
                  nxt_state = ST_L2;
                  nxt_addr  = {mem_data_i[ADDR_W-1:PAGE_BITS],
                               va_q[SUPER_BITS-1:PAGE_BITS], 2'b00};
               end else begin
                  fin      = 1'b1;
                  fin_code = FC_TBL_MISS;
               end
            end else begin
               fin      = 1'b1;
               fin_code = FC_BAD_KIND;
            end
         end
         ST_L2: if (mem_ack_i) begin
            fin = 1'b1;
            if (d_present) begin
               fin_pa   = {mem_data_i[ADDR_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
               fin_perm = d_perm;
               fin_code = p_code;
            end else begin
               fin_code = FC_PAGE_MISS;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
      if (fin) nxt_state = ST_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q        <= ST_IDLE;
         addr_q         <= '0;
         va_q           <= '0;
         acc_q          <= ACC_RD;
         user_q         <= 1'b0;
         done_o         <= 1'b0;
         pa_o           <= '0;
         perm_o         <= '0;
         big_page_o     <= 1'b0;
         fault_code_o   <= FC_NONE;
         itrap_o        <= 1'b0;
         dtrap_o        <= 1'b0;
         fault_status_o <= FC_NONE;
         fault_addr_o   <= '0;
      end else begin
         state_q <= nxt_state;
         addr_q  <= nxt_addr;
         if (state_q == ST_IDLE && req_valid_i) begin
            va_q   <= req_va_i;
            acc_q  <= req_acc_i;
            user_q <= req_user_i;
         end
         done_o  <= fin;
         itrap_o <= fin && (fin_code != FC_NONE) && (acc_q == ACC_EX);
         dtrap_o <= fin && (fin_code != FC_NONE) && (acc_q != ACC_EX);
         if (fin) begin
            pa_o         <= fin_pa;
            perm_o       <= fin_perm;
            big_page_o   <= fin_big;
            fault_code_o <= fin_code;
            if (fin_code != FC_NONE) begin
               fault_status_o <= fin_code;
               fault_addr_o   <= va_q;
            end
         end
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign mem_req_o   = (state_q != ST_IDLE);
   assign mem_addr_o  = addr_q;

   logic unused_base;
   assign unused_base = ^tbl_base_i[PAGE_BITS-1:0];
endmodule

// File: rtl/ptw_xlate_chk.sv
module ptw_xlate_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        req_ready_o,
   input logic        mem_req_o,
   input logic [31:0] mem_addr_o,
   input logic        mem_ack_i,
   input logic        done_o,
   input logic        big_page_o,
   input logic [7:0]  fault_code_o,
   input logic        itrap_o,
   input logic        dtrap_o,
   input logic [7:0]  fault_status_o
);
   // R10
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

   // R9
   busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> !req_ready_o);

   // R8
   trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({itrap_o, dtrap_o}));

   // R8
   trap_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (itrap_o || dtrap_o) |-> done_o && (fault_code_o != 8'h00));

   // R8
   status_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && (fault_code_o != 8'h00) |-> fault_status_o == fault_code_o);

   // R5
   super_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && big_page_o |-> (fault_code_o == 8'h00) || (fault_code_o >= 8'h11 && fault_code_o <= 8'h13));
endmodule

bind ptw_xlate ptw_xlate_chk u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
   .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
   .done_o(done_o), .big_page_o(big_page_o), .fault_code_o(fault_code_o),
   .itrap_o(itrap_o), .dtrap_o(dtrap_o), .fault_status_o(fault_status_o)
);

// File: tb/ptw_xlate_test.sv
`timescale 1ns/1ps
module ptw_xlate_test;
   localparam logic [31:0] BASE = 32'h0010_0000;
   localparam int LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 1'b0, req_user = 1'b0, xlat_en = 1'b0;
   logic [31:0] req_va = '0;
   logic [1:0]  req_acc = '0;
   logic        req_ready, mem_req, mem_ack, done, big, itrap, dtrap;
   logic [31:0] mem_addr, mem_data, pa, faddr;
   logic [2:0]  perm;
   logic [7:0]  fcode, fstat;

   ptw_xlate uut (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_va_i(req_va), .req_acc_i(req_acc), .req_user_i(req_user), .xlat_en_i(xlat_en),
      .tbl_base_i(BASE), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
      .mem_data_i(mem_data), .done_o(done), .pa_o(pa), .perm_o(perm), .big_page_o(big),
      .fault_code_o(fcode), .itrap_o(itrap), .dtrap_o(dtrap), .fault_status_o(fstat),
      .fault_addr_o(faddr)
   );

   typedef struct {
      logic [31:0] pa; logic [2:0] perm; logic big; logic [7:0] code;
      logic ti, td; logic [7:0] stat; logic [31:0] faddr;
      int nrd; logic [31:0] l1a, l2a;
   } item_t;

   item_t exp_q[$];
   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_log [0:255];
   int rd_n = 0, rd_base = 0, n_chk = 0, n_fail = 0, n_done = 0, n_issued = 0, r10_bad = 0;
   logic [7:0]  g_stat = 8'h00;
   logic [31:0] g_faddr = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [7:0] pcode(input logic user, input logic [1:0] acc, input logic [2:0] p);
      if (!user) return 8'h00;
      if ((acc == 2'b00 || acc == 2'b11) && !p[2]) return 8'h11;
      if (acc == 2'b01 && !p[1]) return 8'h12;
      if (acc == 2'b10 && !p[0]) return 8'h13;
      return 8'h00;
   endfunction

   function automatic item_t model(input logic [31:0] va, input logic [1:0] acc,
                                   input logic user, input logic en);
      item_t it;
      logic [31:0] d, d2;
      it = '{pa: 0, perm: 0, big: 0, code: 0, ti: 0, td: 0, stat: 0, faddr: 0, nrd: 0, l1a: 0, l2a: 0};
      if (!en) begin
         it.pa = va; it.perm = 3'b111;
      end else if (!user && !va[31]) begin
         it.pa = va | 32'h8000_0000; it.perm = 3'b111;
      end else begin
         it.l1a = {BASE[31:12], va[31:22], 2'b00}; it.nrd = 1;
         d = rdm(it.l1a);
         if (d[1:0] == 2'b10) begin
            if (!d[2]) it.code = 8'h0B;
            else begin
               it.pa = {d[31:22], va[21:0]}; it.big = 1'b1;
               it.perm = {d[8], d[7], d[6]}; it.code = pcode(user, acc, it.perm);
            end
         end else if (d[1:0] == 2'b00) begin
            if (!d[2]) it.code = 8'h05;
            else begin
               it.l2a = {d[31:12], va[21:12], 2'b00}; it.nrd = 2;
               d2 = rdm(it.l2a);
               if (!d2[2]) it.code = 8'h08;
               else begin
                  it.pa = {d2[31:12], va[11:0]};
                  it.perm = {d2[8], d2[7], d2[6]}; it.code = pcode(user, acc, it.perm);
               end
            end
         end else it.code = 8'h1F;
      end
      if (it.code != 8'h00) begin
         it.ti = (acc == 2'b10); it.td = (acc != 2'b10);
         g_stat = it.code; g_faddr = va;
      end
      it.stat = g_stat; it.faddr = g_faddr;
      return it;
   endfunction

   // memory model: answers each read after LAT idle cycles
   int cnt = 0;
   always @(posedge clk) begin
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         if (cnt == LAT) begin
            mem_ack <= 1'b1; mem_data <= rdm(mem_addr); cnt <= 0;
            rd_log[rd_n % 256] <= mem_addr; rd_n <= rd_n + 1;
         end else cnt <= cnt + 1;
      end
   end
   initial begin mem_ack = 1'b0; mem_data = '0; end

   // R10 address stability watch
   logic p_req = 1'b0, p_ack = 1'b0;
   logic [31:0] p_addr = '0;
   always @(negedge clk) begin
      if (rst_n && mem_req && p_req && !p_ack && mem_addr !== p_addr) r10_bad++;
      p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
   end

   // monitor / scoreboard
   always @(negedge clk) if (rst_n && done) begin
      item_t e;
      n_done++;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", pa, 32'h0);
      else begin
         e = exp_q.pop_front();
         chk(pa === e.pa, "R1 R2 R5 R6 physical address", pa, e.pa);
         chk(perm === e.perm, "R7 permission bits", {29'h0, perm}, {29'h0, e.perm});
         chk(big === e.big, "R5 R6 page size", {31'h0, big}, {31'h0, e.big});
         chk(fcode === e.code, "R4 R5 R6 R7 fault code", {24'h0, fcode}, {24'h0, e.code});
         chk({itrap, dtrap} === {e.ti, e.td}, "R8 trap kind", {30'h0, itrap, dtrap}, {30'h0, e.ti, e.td});
         chk(fstat === e.stat, "R8 fault status", {24'h0, fstat}, {24'h0, e.stat});
         chk(faddr === e.faddr, "R8 fault address", faddr, e.faddr);
         chk(rd_n - rd_base == e.nrd, "R1 R2 R3 read count", rd_n - rd_base, e.nrd);
         if (e.nrd >= 1 && rd_n - rd_base >= 1)
            chk(rd_log[rd_base % 256] === e.l1a, "R3 first-level address", rd_log[rd_base % 256], e.l1a);
         if (e.nrd == 2 && rd_n - rd_base >= 2)
            chk(rd_log[(rd_base + 1) % 256] === e.l2a, "R3 second-level address", rd_log[(rd_base + 1) % 256], e.l2a);
         rd_base = rd_n;
      end
   end

   task automatic issue(input logic [31:0] va, input logic [1:0] acc, input logic user, input logic en);
      exp_q.push_back(model(va, acc, user, en));
      n_issued++;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user; xlat_en = en;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d pending expected 0", exp_q.size());
      summary();
      $finish;
   end

   initial begin
      // level one
      mem[{BASE[31:12], 10'h200, 2'b00}] = 32'h0020_0004;            // table present
      mem[{BASE[31:12], 10'h201, 2'b00}] = 32'h1C00_0186;            // superpage r,w
      mem[{BASE[31:12], 10'h202, 2'b00}] = 32'h1C40_0002;            // superpage absent
      mem[{BASE[31:12], 10'h203, 2'b00}] = 32'h0030_0000;            // table absent
      mem[{BASE[31:12], 10'h204, 2'b00}] = 32'h0000_0005;            // bad kind 01
      mem[{BASE[31:12], 10'h004, 2'b00}] = 32'h2480_01C6;            // superpage rwx
      // level two
      mem[32'h0020_0000 + 32'd20] = 32'h3333_31C6;                   // rwx
      mem[32'h0020_0000 + 32'd24] = 32'h4444_4106;                   // read only
      mem[32'h0020_0000 + 32'd28] = 32'h0000_0000;                   // absent
      mem[32'h0020_0000 + 32'd32] = 32'h5555_5046;                   // exec only

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(req_ready === 1'b1 && done === 1'b0 && mem_req === 1'b0, "R9 reset idle",
          {29'h0, req_ready, done, mem_req}, 32'h4);
      chk(fstat === 8'h00 && faddr === 32'h0, "R8 reset status", {24'h0, fstat}, 32'h0);

      issue(32'h1234_5678, 2'b00, 1'b1, 1'b0);   // R1 bypass off
      issue(32'h0012_3456, 2'b01, 1'b0, 1'b1);   // R2 kernel low
      issue(32'h8000_5ABC, 2'b00, 1'b1, 1'b1);   // R6 page ok
      issue(32'h8000_6010, 2'b01, 1'b1, 1'b1);   // R7 write denied
      // R9 request while busy must be ignored
      req_valid = 1'b1; req_va = 32'h0000_0040; req_acc = 2'b00; req_user = 1'b0; xlat_en = 1'b0;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      issue(32'h8000_6010, 2'b01, 1'b0, 1'b1);   // R7 kernel not faulted
      issue(32'h8000_6010, 2'b10, 1'b1, 1'b1);   // R7 exec denied, R8 itrap
      issue(32'h8000_7000, 2'b00, 1'b1, 1'b1);   // R6 page miss
      issue(32'h8000_8FFC, 2'b10, 1'b1, 1'b1);   // R7 exec ok
      issue(32'h8040_1234, 2'b00, 1'b1, 1'b1);   // R5 superpage
      issue(32'h8040_1234, 2'b10, 1'b1, 1'b1);   // R7 superpage exec denied
      issue(32'h8080_0000, 2'b00, 1'b0, 1'b1);   // R5 superpage miss
      issue(32'h80C0_0000, 2'b00, 1'b1, 1'b1);   // R6 table miss
      issue(32'h8100_0000, 2'b01, 1'b0, 1'b1);   // R4 bad kind
      issue(32'h0100_0ABC, 2'b00, 1'b1, 1'b1);   // R2 user low walks
      issue(32'h8000_6FFF, 2'b11, 1'b1, 1'b1);   // R7 kind 11 reads
      issue(32'h8000_6FFF, 2'b11, 1'b1, 1'b0);   // R1 again, R8 status held

      while (exp_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(n_done == n_issued, "R9 one done per request", n_done, n_issued);
      chk(r10_bad == 0, "R10 address held until ack", r10_bad, 0);
      summary();
      $finish;
   end
endmodule